// File: doc/BRIEF.md
# Trigger Window Matcher Pool with Event Formatter

This block collects detector hits that belong to each accepted trigger and emits them as framed events. Every trigger claims the next matcher in a fixed rotation. From the cycle after the claim, that matcher compares the crossing number of each incoming hit against an inclusive window around the trigger's crossing number. It stores each matching hit in its own small FIFO. Once the hit stream, or the crossing strobe, moves past the window's upper edge, the matcher is complete.

A formatter walks the matchers in the same rotation, and so in trigger order. For each event it writes one header word, then data words with up to five hits each, then one trailer word. A trigger queue in the formatter holds the header fields of each accepted trigger until its event goes out. Two single-cycle error pulses report a trigger dropped because the next matcher in the rotation was still busy, and a hit lost because a matcher FIFO was full.

Top module: `trig_window_pool`

## Requirements
- R1: While reset is held and after its release with no stimulus, `out_valid`, `trg_drop` and `hit_drop` are low and no word is emitted.
- R2: A trigger with crossing T opens a window [T-BEFORE, T+AFTER], inclusive at both ends, with defaults BEFORE=2 and AFTER=2. Hits are compared from the cycle after the trigger. The hit crossing number is bits [11:0] of the hit. Hits at either edge are stored, and hits one crossing outside are not.
- R3: Window arithmetic is modulo 4096, so a window that straddles crossing 4095 and crossing 0 captures hits on both sides.
- R4: An open matcher closes when a hit arrives whose crossing lies 1 to 2047 crossings above the upper edge, or when `bx_strobe` is high and `ttc_bcn` lies in that range. Later hits are not stored, even if they fall inside the window.
- R5: A hit that falls inside the windows of several open matchers is stored in each of them.
- R6: The header has tag 2'b01 at [229:228], with the event number at [11:0], the crossing at [23:12] and the orbit at [35:24]. The trailer has tag 2'b11, with the hit count at [11:0] and the event number at [23:12]. A header is followed in the next cycle by a data word or a trailer.
- R7: A data word has tag 2'b10 and its hit count (1 to 5) at [227:225]. Hit k sits at [41k+40:41k], hits are in arrival order, and unused slots are zero. An event with n hits uses ceil(n/5) data words, and an event with no hits uses none.
- R8: Events leave in trigger order. Matchers are used in round-robin order.
- R9: A trigger is dropped if the next matcher in the rotation is not free. The drop raises `trg_drop` for one cycle, and no event is emitted for that trigger.
- R10: Each matcher stores at most DEPTH (default 8) hits. Every hit refused for that reason raises `hit_drop` for one cycle, and the trailer reports DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trg_valid | input | 1 | Trigger accepted this cycle |
| bx_strobe | input | 1 | Crossing strobe; `ttc_bcn` holds the current crossing |
| ttc_bcn | input | 12 | Crossing number (trigger crossing when `trg_valid`) |
| ttc_orn | input | 12 | Orbit number of the trigger |
| ttc_evn | input | 12 | Event number of the trigger |
| hit_valid | input | 1 | Hit present |
| hit_data | input | 41 | Hit word, crossing in [11:0] |
| out_word | output | 230 | Header, data or trailer word |
| out_valid | output | 1 | `out_word` is valid |
| trg_drop | output | 1 | Trigger dropped (pulse) |
| hit_drop | output | 1 | Hit lost on full FIFO (pulse) |

## Verification
The bench places hits exactly on both window edges and one crossing beyond each. A design with an off-by-one window either gains or loses a hit there, which changes the data count and the trailer. It also runs a window across crossing wrap, where unsigned comparison without modulo arithmetic would drop the hits near zero. It sends a hit inside the window after the matcher has closed, and overlapping windows that must share one hit. It also overfills a FIFO, and issues one trigger more than the pool holds. A wrong design there would count the late hit, would miss the shared hit, would write past the FIFO, or would overwrite a busy matcher and reorder or lose events.

// File: rtl/trig_window_pool.sv
module trig_window_pool #(
  parameter int NMATCH  = 32,
  parameter int DEPTH   = 8,
  parameter int HIT_W   = 41,
  parameter int BCN_LSB = 0,
  parameter int BEFORE  = 2,
  parameter int AFTER   = 2,
  parameter int HPW     = 5,
  parameter int WORD_W  = 230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trg_valid,
  input  logic              bx_strobe,
  input  logic [11:0]       ttc_bcn,
  input  logic [11:0]       ttc_orn,
  input  logic [11:0]       ttc_evn,
  input  logic              hit_valid,
  input  logic [HIT_W-1:0]  hit_data,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              trg_drop,
  output logic              hit_drop
);
  localparam int MI_W  = $clog2(NMATCH);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int SPAN  = BEFORE + AFTER;

  typedef enum logic {F_IDLE, F_BODY} fstate_t;

  function automatic logic beyond(input logic [11:0] b, input logic [11:0] lo);
    logic [11:0] d;
    d = b - lo - 12'(SPAN);
    return (d != 12'd0) && !d[11];
  endfunction

  logic [11:0] hbcn;
  assign hbcn = hit_data[BCN_LSB +: 12];

  logic [NMATCH-1:0]            open_q, done_q;
  logic [NMATCH-1:0][11:0]      lo_q;
  logic [NMATCH-1:0][CNT_W-1:0] cnt_q;
  logic [HIT_W-1:0]             mem_q [NMATCH][DEPTH];
  logic [35:0]                  tq_q  [NMATCH];
  logic [MI_W-1:0]              wr_q, rd_q;
  logic [NMATCH-1:0]            grab, close, full;
  fstate_t                      fs_q;
  logic [CNT_W-1:0]             idx_q;

  logic take;
  assign take = trg_valid && !open_q[wr_q] && !done_q[wr_q];

  for (genvar g = 0; g < NMATCH; g++) begin : g_match
    logic [11:0] dw;
    assign dw       = hbcn - lo_q[g];
    assign grab[g]  = open_q[g] && hit_valid && (dw <= 12'(SPAN));
    assign close[g] = open_q[g] && ((hit_valid && beyond(hbcn, lo_q[g])) ||
                                    (bx_strobe && beyond(ttc_bcn, lo_q[g])));
    assign full[g]  = grab[g] && (cnt_q[g] == CNT_W'(DEPTH));
  end

  logic [CNT_W-1:0] rem, nw;
  assign rem = cnt_q[rd_q] - idx_q;
  assign nw  = (rem > CNT_W'(HPW)) ? CNT_W'(HPW) : rem;

  logic [WORD_W-1:0] hdr_w, trl_w, dat_w;
  always_comb begin
    hdr_w = '0;
    hdr_w[WORD_W-1 -: 2] = 2'b01;
    hdr_w[35:0] = tq_q[rd_q];
    trl_w = '0;
    trl_w[WORD_W-1 -: 2] = 2'b11;
    trl_w[23:12] = tq_q[rd_q][11:0];
    trl_w[11:0]  = 12'(cnt_q[rd_q]);
  end

  always_comb begin
    logic [CNT_W-1:0] pos;
    dat_w = '0;
    dat_w[WORD_W-1 -: 2] = 2'b10;
    dat_w[WORD_W-3 -: 3] = 3'(nw);
    for (int k = 0; k < HPW; k++) begin
      pos = idx_q + CNT_W'(k);
      if (CNT_W'(k) < nw) dat_w[k*HIT_W +: HIT_W] = mem_q[rd_q][pos[IDX_W-1:0]];
    end
  end

  logic release_ev;
  assign release_ev = (fs_q == F_BODY) && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      done_q    <= '0;
      lo_q      <= '0;
      cnt_q     <= '0;
      wr_q      <= '0;
      rd_q      <= '0;
      fs_q      <= F_IDLE;
      idx_q     <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
      trg_drop  <= 1'b0;
      hit_drop  <= 1'b0;
    end else begin
      trg_drop  <= trg_valid && !take;
      hit_drop  <= |full;
      out_valid <= 1'b0;
      for (int g = 0; g < NMATCH; g++) begin
        if (take && wr_q == MI_W'(g)) begin
          open_q[g] <= 1'b1;
          lo_q[g]   <= ttc_bcn - 12'(BEFORE);
          cnt_q[g]  <= '0;
        end else begin
          if (close[g]) begin
            open_q[g] <= 1'b0;
            done_q[g] <= 1'b1;
          end
          if (grab[g] && !full[g]) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
        end
        if (release_ev && rd_q == MI_W'(g)) done_q[g] <= 1'b0;
      end
      if (take) wr_q <= wr_q + MI_W'(1);
      case (fs_q)
        F_IDLE: if (done_q[rd_q]) begin
          out_valid <= 1'b1;
          out_word  <= hdr_w;
          idx_q     <= '0;
          fs_q      <= F_BODY;
        end
        F_BODY: begin
          out_valid <= 1'b1;
          if (rem == '0) begin
            out_word <= trl_w;
            rd_q     <= rd_q + MI_W'(1);
            fs_q     <= F_IDLE;
          end else begin
            out_word <= dat_w;
            idx_q    <= idx_q + nw;
          end
        end
        default: fs_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) tq_q[wr_q] <= {ttc_orn, ttc_bcn, ttc_evn};
    for (int g = 0; g < NMATCH; g++)
      if (grab[g] && !full[g]) mem_q[g][cnt_q[g][IDX_W-1:0]] <= hit_data;
  end
endmodule

// File: rtl/trig_window_pool_chk.sv
module trig_window_pool_chk #(
  parameter int WORD_W = 230,
  parameter int HPW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trg_valid,
  input logic              hit_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_valid,
  input logic              trg_drop,
  input logic              hit_drop
);
  logic [1:0] tag;
  logic [2:0] nh;
  assign tag = out_word[WORD_W-1 -: 2];
  assign nh  = out_word[WORD_W-3 -: 3];

  a_r9_drop_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    trg_drop |-> $past(trg_valid));
  a_r10_drop_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_drop |-> $past(hit_valid));
  a_r6_tag_known: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> tag != 2'b00);
  a_r6_header_then_body: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tag == 2'b01) |=> (out_valid && tag != 2'b01));
  a_r6_trailer_not_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tag == 2'b11) |=> !(out_valid && tag == 2'b10));
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tag == 2'b10) |-> (nh != 3'd0 && nh <= 3'(HPW)));
endmodule

bind trig_window_pool trig_window_pool_chk #(.WORD_W(WORD_W), .HPW(HPW)) i_chk (
  .clk(clk), .rst_n(rst_n), .trg_valid(trg_valid), .hit_valid(hit_valid),
  .out_word(out_word), .out_valid(out_valid), .trg_drop(trg_drop), .hit_drop(hit_drop));

// File: tb/test_trig_window_pool.sv
module test_trig_window_pool;
  localparam int HIT_W = 41;
  localparam int WORD_W = 230;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trg_valid = 1'b0, bx_strobe = 1'b0, hit_valid = 1'b0;
  logic [11:0] ttc_bcn = '0, ttc_orn = '0, ttc_evn = '0;
  logic [HIT_W-1:0] hit_data = '0;
  logic [WORD_W-1:0] out_word;
  logic out_valid, trg_drop, hit_drop;

  always #2 clk = ~clk;

  trig_window_pool i_trig_window_pool (
    .clk(clk), .rst_n(rst_n), .trg_valid(trg_valid), .bx_strobe(bx_strobe),
    .ttc_bcn(ttc_bcn), .ttc_orn(ttc_orn), .ttc_evn(ttc_evn),
    .hit_valid(hit_valid), .hit_data(hit_data), .out_word(out_word),
    .out_valid(out_valid), .trg_drop(trg_drop), .hit_drop(hit_drop));

  int n_chk = 0, n_err = 0, n_ow = 0, n_td = 0, n_hd = 0;
  logic [WORD_W-1:0] ow [256];

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin ow[n_ow] = out_word; n_ow++; end
    if (trg_drop) n_td++;
    if (hit_drop) n_hd++;
  end

  // {expected_in_window, crossing}; trigger crossing 100, window 98..102
  localparam logic [12:0] VEC [9] = '{
    {1'b0, 12'd96}, {1'b0, 12'd97}, {1'b1, 12'd98}, {1'b1, 12'd99}, {1'b1, 12'd100},
    {1'b1, 12'd101}, {1'b1, 12'd102}, {1'b0, 12'd103}, {1'b0, 12'd101}};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tg(input logic [WORD_W-1:0] w); return w[229:228]; endfunction
  function automatic logic [2:0] nf(input logic [WORD_W-1:0] w); return w[227:225]; endfunction
  function automatic logic [HIT_W-1:0] hk(input logic [WORD_W-1:0] w, input int k);
    return w[k*HIT_W +: HIT_W];
  endfunction

  task automatic trig(input logic [11:0] b, input logic [11:0] o, input logic [11:0] e);
    trg_valid = 1'b1; ttc_bcn = b; ttc_orn = o; ttc_evn = e;
    @(negedge clk); trg_valid = 1'b0;
  endtask
  task automatic hit(input logic [11:0] b, input logic [28:0] p);
    hit_valid = 1'b1; hit_data = {p, b};
    @(negedge clk); hit_valid = 1'b0;
  endtask
  task automatic strobe(input logic [11:0] b);
    bx_strobe = 1'b1; ttc_bcn = b;
    @(negedge clk); bx_strobe = 1'b0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic check_hdr(input string req, input int i, input int e, input int b, input int o);
    check({req, " header tag"}, 64'(tg(ow[i])), 64'd1);
    check({req, " header evn"}, 64'(ow[i][11:0]), 64'(e));
    check({req, " header bcn"}, 64'(ow[i][23:12]), 64'(b));
    check({req, " header orn"}, 64'(ow[i][35:24]), 64'(o));
  endtask
  task automatic check_trl(input string req, input int i, input int e, input int c);
    check({req, " trailer tag"}, 64'(tg(ow[i])), 64'd3);
    check({req, " trailer evn"}, 64'(ow[i][23:12]), 64'(e));
    check({req, " trailer count"}, 64'(ow[i][11:0]), 64'(c));
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #600000;
    n_err++;
    $display("FAIL watchdog expired");
    report;
    $finish;
  end

  initial begin
    int base, j, td0, hd0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 64'(out_valid), 64'd0);
    check("R1 trg_drop in reset", 64'(trg_drop), 64'd0);
    check("R1 hit_drop in reset", 64'(hit_drop), 64'd0);
    rst_n = 1'b1;
    idle(5);
    check("R1 no words after reset", 64'(n_ow), 64'd0);

    // R2 / R4: window edges, close by hit, late hit ignored
    base = n_ow;
    trig(12'd100, 12'd7, 12'd1);
    for (int i = 0; i < 9; i++) hit(VEC[i][11:0], 29'(i + 1));
    idle(10);
    check("R2 word count", 64'(n_ow - base), 64'd3);
    check_hdr("R6", base, 1, 100, 7);
    check("R7 data tag", 64'(tg(ow[base+1])), 64'd2);
    check("R2 edges included count", 64'(nf(ow[base+1])), 64'd5);
    j = 0;
    for (int i = 0; i < 9; i++) if (VEC[i][12]) begin
      check("R2 stored hit", 64'(hk(ow[base+1], j)), 64'({29'(i + 1), VEC[i][11:0]}));
      j++;
    end
    check_trl("R4", base + 2, 1, 5);

    // R3: wrap
    base = n_ow;
    trig(12'd4095, 12'd8, 12'd2);
    hit(12'd4092, 29'h10); hit(12'd4093, 29'h11); hit(12'd0, 29'h12);
    hit(12'd1, 29'h13); hit(12'd2, 29'h14);
    idle(10);
    check("R3 word count", 64'(n_ow - base), 64'd3);
    check("R3 wrap count", 64'(nf(ow[base+1])), 64'd3);
    check("R3 hit 4093", 64'(hk(ow[base+1], 0)), 64'({29'h11, 12'd4093}));
    check("R3 hit 0", 64'(hk(ow[base+1], 1)), 64'({29'h12, 12'd0}));
    check("R3 hit 1", 64'(hk(ow[base+1], 2)), 64'({29'h13, 12'd1}));
    check_trl("R3", base + 2, 2, 3);

    // R7 packing, R4 close by strobe
    base = n_ow;
    trig(12'd200, 12'd9, 12'd3);
    for (int i = 0; i < 7; i++) hit(12'd200, 29'(100 + i));
    strobe(12'd203);
    idle(10);
    check("R7 word count", 64'(n_ow - base), 64'd4);
    check("R7 first word n", 64'(nf(ow[base+1])), 64'd5);
    check("R7 second word n", 64'(nf(ow[base+2])), 64'd2);
    check("R7 hit order", 64'(hk(ow[base+2], 1)), 64'({29'(106), 12'd200}));
    check("R7 unused slot zero", 64'(hk(ow[base+2], 2)), 64'd0);
    check_trl("R4 strobe", base + 3, 3, 7);

    // R10 overflow
    base = n_ow; hd0 = n_hd;
    trig(12'd400, 12'd9, 12'd4);
    for (int i = 0; i < 10; i++) hit(12'd400, 29'(200 + i));
    strobe(12'd403);
    idle(10);
    check("R10 drop pulses", 64'(n_hd - hd0), 64'd2);
    check("R10 word count", 64'(n_ow - base), 64'd4);
    check("R10 last kept hit", 64'(hk(ow[base+2], 2)), 64'({29'(207), 12'd400}));
    check_trl("R10", base + 3, 4, 8);

    // R5 overlapping windows, R8 order
    base = n_ow;
    trig(12'd600, 12'd1, 12'd5);
    trig(12'd601, 12'd1, 12'd6);
    hit(12'd598, 29'h21); hit(12'd600, 29'h22); hit(12'd603, 29'h23); hit(12'd604, 29'h24);
    idle(12);
    check("R5 word count", 64'(n_ow - base), 64'd6);
    check_hdr("R8 first", base, 5, 600, 1);
    check("R5 first hit a", 64'(hk(ow[base+1], 0)), 64'({29'h21, 12'd598}));
    check("R5 first shared", 64'(hk(ow[base+1], 1)), 64'({29'h22, 12'd600}));
    check_trl("R5 first", base + 2, 5, 2);
    check_hdr("R8 second", base + 3, 6, 601, 1);
    check("R5 second shared", 64'(hk(ow[base+4], 0)), 64'({29'h22, 12'd600}));
    check("R5 second edge", 64'(hk(ow[base+4], 1)), 64'({29'h23, 12'd603}));
    check_trl("R5 second", base + 5, 6, 2);

    // R9 pool exhausted, R8 order across the rotation
    base = n_ow; td0 = n_td;
    for (int i = 0; i < 33; i++) trig(12'(800 + i), 12'd2, 12'(100 + i));
    idle(2);
    check("R9 drop pulses", 64'(n_td - td0), 64'd1);
    strobe(12'd840);
    idle(90);
    check("R9 word count", 64'(n_ow - base), 64'd64);
    for (int i = 0; i < 32; i++) begin
      check("R8 header evn", 64'(ow[base + 2*i][11:0]), 64'(100 + i));
      check("R7 empty event trailer", 64'(tg(ow[base + 2*i + 1])), 64'd3);
    end
    check("R9 dropped event absent", 64'(ow[base + 62][11:0]), 64'd131);

    report;
    $finish;
  end
endmodule